// File: doc/BRIEF.md
# Debug Mode Entry/Exit Controller

This block decides when a processor core stops for debugging and when it resumes. Exception events from the core are recorded in a sticky cause register. A second register, written by debug software over a small register bus, holds a mask of enable bits. When any recorded cause has its enable bit set, the block raises a freeze output and enters debug mode.

On entry the block copies the current program counter into a return-address register and the current machine state into a saved-state register. It also drives a working machine state with the external-interrupt enable bit cleared, so that external and timer interrupts are ignored while frozen. Events that arrive while frozen are only recorded. They never reload the save registers. They do raise a summary flag, which tells an external tool to inspect the cause register. Breakpoint and watchpoint requests are suppressed for as long as freeze is high.

A return strobe leaves debug mode and restores the saved machine state. If an enabled cause is still set at that moment, the block stays frozen at once. Software is therefore expected to read the cause register before it returns. Reading that register also clears it.

Top module: `dbgmode_ctrl`

## Requirements
- R1: After synchronous reset, freeze, summary, breakpoint and watchpoint outputs are 0 and a read of the cause register returns 0.
- R2: A bus write with address 1 loads the enable register. A bus read returns data on `bus_rdata` one cycle after the read strobe: address 0 gives the cause register and address 1 gives the enable register.
- R3: Recognized event bits set cause bits that stay set (sticky). A read at address 0 clears the bits that were set before it. An event bit that is new in the same cycle as the read is kept.
- R4: Event bits outside the recognized mask (default: every bit except bit 31) are never recorded and never cause entry, even when enabled.
- R5: While not frozen, if the cause register AND the enable register is nonzero, freeze rises on the next clock. This is two clocks after a one-cycle event pulse. An event whose enable bit is clear does not freeze.
- R6: On the entry clock, `save_pc` and `save_msr` capture `cur_pc` and `cur_msr`, and `msr_out` becomes `cur_msr` with the interrupt-enable bit (bit 15) cleared.
- R7: While frozen, `save_pc`, `save_msr` and `msr_out` hold their values, even when new exceptions arrive or the core inputs change.
- R8: Outside debug mode, `bp_event` and `wp_event` are one-cycle-delayed copies of the requests. While frozen they stay 0, whatever the recoverable-interrupt bit (bit 1) of `cur_msr` is.
- R9: `exc_summary` is 1 on the cycle after any recognized event seen while frozen, and 0 otherwise.
- R10: A return strobe while frozen, with no enabled cause pending, drops freeze on the next clock. In that same cycle `msr_out` is set to `save_msr`.
- R11: A return strobe while an enabled cause is pending keeps freeze high and leaves the save registers and `msr_out` unchanged.
- R12: Outside debug mode the return strobe has no effect, and `msr_out` follows `cur_msr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | CAUSE_W | Exception event bits (pulses or levels) |
| rfi_strobe | input | 1 | Return-from-interrupt strobe |
| cur_pc | input | PC_W | Current program counter |
| cur_msr | input | MSR_W | Current machine state |
| bp_req | input | 1 | Breakpoint request from comparators |
| wp_req | input | 1 | Watchpoint request from comparators |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_re | input | 1 | Register bus read strobe |
| bus_wdata | input | CAUSE_W | Register bus write data |
| bus_rdata | output | CAUSE_W | Register bus read data, registered |
| freeze | output | 1 | High while in debug mode |
| save_pc | output | PC_W | Return address saved on entry |
| save_msr | output | MSR_W | Machine state saved on entry |
| msr_out | output | MSR_W | Working machine state driven back to the core |
| exc_summary | output | 1 | Exception seen while frozen |
| bp_event | output | 1 | Gated breakpoint event |
| wp_event | output | 1 | Gated watchpoint event |

## Verification
The properties assume that reset is held over the first clock edge, and that the core inputs are defined at every edge once reset is released. They also assume that debug software writes the enable register only through the bus, not in the same cycle as a return strobe whose outcome the bench checks. The stimulus changes inputs only on falling edges. It clears the cause register before every return that is meant to exit, and it changes the core's machine state while frozen to show that the saved copies hold.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int unsigned REG_CAUSE  = 0;
  localparam int unsigned REG_ENABLE = 1;

  typedef enum logic {
    MODE_RUN    = 1'b0,
    MODE_FROZEN = 1'b1
  } mode_e;
endpackage

// File: rtl/dbgm_cause_bank.sv
module dbgm_cause_bank
  import dbgm_pkg::*;
#(
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter logic [CAUSE_W-1:0] RECOG_MASK = {1'b0, {(CAUSE_W-1){1'b1}}}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_W-1:0] evt_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [CAUSE_W-1:0] bus_wdata,
  output logic [CAUSE_W-1:0] bus_rdata,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [CAUSE_W-1:0] enable_o,
  output logic [CAUSE_W-1:0] evt_rec_o
);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(REG_CAUSE);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(REG_ENABLE);

  logic [CAUSE_W-1:0] cause_q, cause_d, enable_q, evt_rec;
  logic               rd_cause;

  assign rd_cause = bus_re && (bus_addr == A_CAUSE);

  for (genvar gi = 0; gi < CAUSE_W; gi++) begin : g_bit
    if (RECOG_MASK[gi]) begin : g_rec
      assign evt_rec[gi] = evt_in[gi];
      // clear wins only over bits already set; a fresh event survives the read
      assign cause_d[gi] = rd_cause ? (evt_in[gi] & ~cause_q[gi])
                                    : (cause_q[gi] | evt_in[gi]);
    end else begin : g_ign
      assign evt_rec[gi] = 1'b0;
      assign cause_d[gi] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q   <= '0;
      enable_q  <= '0;
      bus_rdata <= '0;
    end else begin
      cause_q <= cause_d;
      if (bus_we && (bus_addr == A_ENABLE)) enable_q <= bus_wdata;
      if (bus_re) begin
        if (bus_addr == A_CAUSE)       bus_rdata <= cause_q;
        else if (bus_addr == A_ENABLE) bus_rdata <= enable_q;
        else                           bus_rdata <= '0;
      end
    end
  end

  assign cause_o   = cause_q;
  assign enable_o  = enable_q;
  assign evt_rec_o = evt_rec;
endmodule

// File: rtl/dbgm_mode_fsm.sv
module dbgm_mode_fsm
  import dbgm_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned MSR_W  = 32,
  parameter int unsigned EE_BIT = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             rfi_strobe,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [MSR_W-1:0] cur_msr,
  output logic             freeze_o,
  output logic [PC_W-1:0]  save_pc_o,
  output logic [MSR_W-1:0] save_msr_o,
  output logic [MSR_W-1:0] msr_o
);
  localparam logic [MSR_W-1:0] EE_MASK = MSR_W'(1) << EE_BIT;

  mode_e            mode_q;
  logic [PC_W-1:0]  spc_q;
  logic [MSR_W-1:0] smsr_q, msr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RUN;
      spc_q  <= '0;
      smsr_q <= '0;
      msr_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_RUN: begin
          if (pending) begin
            mode_q <= MODE_FROZEN;
            spc_q  <= cur_pc;
            smsr_q <= cur_msr;
            msr_q  <= cur_msr & ~EE_MASK;
          end else begin
            msr_q <= cur_msr;
          end
        end
        MODE_FROZEN: begin
          // an enabled cause left pending bounces the return straight back
          if (rfi_strobe && !pending) begin
            mode_q <= MODE_RUN;
            msr_q  <= smsr_q;
          end
        end
        default: mode_q <= MODE_RUN;
      endcase
    end
  end

  assign freeze_o   = (mode_q == MODE_FROZEN);
  assign save_pc_o  = spc_q;
  assign save_msr_o = smsr_q;
  assign msr_o      = msr_q;
endmodule

// File: rtl/dbgm_event_gate.sv
module dbgm_event_gate #(
  parameter int unsigned CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freeze,
  input  logic               bp_req,
  input  logic               wp_req,
  input  logic [CAUSE_W-1:0] evt_rec,
  output logic               bp_event_o,
  output logic               wp_event_o,
  output logic               summary_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bp_event_o <= 1'b0;
      wp_event_o <= 1'b0;
      summary_o  <= 1'b0;
    end else begin
      bp_event_o <= bp_req && !freeze;
      wp_event_o <= wp_req && !freeze;
      summary_o  <= freeze && (evt_rec != '0);
    end
  end
endmodule

// File: rtl/dbgmode_ctrl.sv
module dbgmode_ctrl #(
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned MSR_W   = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned EE_BIT  = 15,
  parameter logic [CAUSE_W-1:0] RECOG_MASK = {1'b0, {(CAUSE_W-1){1'b1}}}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_W-1:0] evt_in,
  input  logic               rfi_strobe,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic [MSR_W-1:0]   cur_msr,
  input  logic               bp_req,
  input  logic               wp_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [CAUSE_W-1:0] bus_wdata,
  output logic [CAUSE_W-1:0] bus_rdata,
  output logic               freeze,
  output logic [PC_W-1:0]    save_pc,
  output logic [MSR_W-1:0]   save_msr,
  output logic [MSR_W-1:0]   msr_out,
  output logic               exc_summary,
  output logic               bp_event,
  output logic               wp_event
);
  logic [CAUSE_W-1:0] cause_w, enable_w, evt_rec_w;
  logic               pending;

  dbgm_cause_bank #(
    .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W), .RECOG_MASK(RECOG_MASK)
  ) u_bank (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cause_o(cause_w), .enable_o(enable_w), .evt_rec_o(evt_rec_w)
  );

  assign pending = (cause_w & enable_w) != '0;

  dbgm_mode_fsm #(
    .PC_W(PC_W), .MSR_W(MSR_W), .EE_BIT(EE_BIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .pending(pending), .rfi_strobe(rfi_strobe),
    .cur_pc(cur_pc), .cur_msr(cur_msr), .freeze_o(freeze),
    .save_pc_o(save_pc), .save_msr_o(save_msr), .msr_o(msr_out)
  );

  dbgm_event_gate #(.CAUSE_W(CAUSE_W)) u_gate (
    .clk(clk), .rst(rst), .freeze(freeze), .bp_req(bp_req), .wp_req(wp_req),
    .evt_rec(evt_rec_w), .bp_event_o(bp_event), .wp_event_o(wp_event),
    .summary_o(exc_summary)
  );
endmodule

// File: rtl/dbgmode_ctrl_chk.sv
module dbgmode_ctrl_chk #(
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned MSR_W   = 32,
  parameter int unsigned EE_BIT  = 15
) (
  input logic               clk,
  input logic               rst,
  input logic               freeze,
  input logic               pending,
  input logic               rfi_strobe,
  input logic [CAUSE_W-1:0] evt_rec,
  input logic               bp_event,
  input logic               wp_event,
  input logic               exc_summary,
  input logic [PC_W-1:0]    save_pc,
  input logic [MSR_W-1:0]   save_msr,
  input logic [MSR_W-1:0]   msr_out
);
  assert_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (!freeze && pending) |=> freeze);

  assert_ee_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze) |-> !msr_out[EE_BIT]);

  assert_save_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (freeze && $past(freeze)) |-> ($stable(save_pc) && $stable(save_msr) && $stable(msr_out)));

  assert_bp_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    freeze |=> (!bp_event && !wp_event));

  assert_summary_R9: assert property (@(posedge clk) disable iff (rst)
    (freeze && (evt_rec != '0)) |=> exc_summary);

  assert_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (freeze && rfi_strobe && !pending) |=> (!freeze && msr_out == $past(save_msr)));

  assert_bounce_R11: assert property (@(posedge clk) disable iff (rst)
    (freeze && rfi_strobe && pending) |=> freeze);

  assert_run_rfi_R12: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !pending) |=> !freeze);
endmodule

bind dbgmode_ctrl dbgmode_ctrl_chk #(
  .CAUSE_W(CAUSE_W), .PC_W(PC_W), .MSR_W(MSR_W), .EE_BIT(EE_BIT)
) u_chk (
  .clk(clk), .rst(rst), .freeze(freeze), .pending(pending),
  .rfi_strobe(rfi_strobe), .evt_rec(evt_rec_w), .bp_event(bp_event),
  .wp_event(wp_event), .exc_summary(exc_summary), .save_pc(save_pc),
  .save_msr(save_msr), .msr_out(msr_out)
);

// File: tb/tb_dbgmode_ctrl.sv
`timescale 1ns/1ps
module tb_dbgmode_ctrl;
  localparam int SEL_FRZ = 0, SEL_SPC = 1, SEL_SMSR = 2, SEL_MSR = 3,
                 SEL_SUM = 4, SEL_BP = 5, SEL_WP = 6, SEL_RD = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_in = '0, cur_pc = '0, cur_msr = '0, bus_wdata = '0;
  logic        rfi_strobe = 1'b0, bp_req = 1'b0, wp_req = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata, save_pc, save_msr, msr_out;
  logic        freeze, exc_summary, bp_event, wp_event;

  dbgmode_ctrl dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .rfi_strobe(rfi_strobe),
    .cur_pc(cur_pc), .cur_msr(cur_msr), .bp_req(bp_req), .wp_req(wp_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .freeze(freeze),
    .save_pc(save_pc), .save_msr(save_msr), .msr_out(msr_out),
    .exc_summary(exc_summary), .bp_event(bp_event), .wp_event(wp_event)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t sbq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [31:0] pick(int sel);
    case (sel)
      SEL_FRZ:  return {31'd0, freeze};
      SEL_SPC:  return save_pc;
      SEL_SMSR: return save_msr;
      SEL_MSR:  return msr_out;
      SEL_SUM:  return {31'd0, exc_summary};
      SEL_BP:   return {31'd0, bp_event};
      SEL_WP:   return {31'd0, wp_event};
      default:  return bus_rdata;
    endcase
  endfunction

  task automatic expect_in(int dly, int sel, logic [31:0] v, string req);
    sbq.push_back('{cyc + dly, sel, v, req});
  endtask

  // monitor: compare every item that falls due at this falling edge
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        logic [31:0] act;
        act = pick(sbq[i].sel);
        n_chk++;
        if (act !== sbq[i].val) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h at cycle %0d",
                   sbq[i].req, sbq[i].sel, act, sbq[i].val, cyc);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    rst = 1'b0;
    bus_re = 1'b1; bus_addr = 2'd0;
    expect_in(1, SEL_FRZ, 0, "R1");
    expect_in(1, SEL_SUM, 0, "R1");
    expect_in(1, SEL_BP, 0, "R1");
    expect_in(1, SEL_RD, 0, "R1");
    tick(1); bus_re = 1'b0;
    // R2 enable write and readback
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0000_0011;
    tick(1); bus_we = 1'b0; bus_re = 1'b1;
    expect_in(1, SEL_RD, 32'h11, "R2");
    tick(1); bus_re = 1'b0;
    // R8 / R12 normal operation
    cur_msr = 32'h0000_8002; cur_pc = 32'h1000; bp_req = 1'b1; wp_req = 1'b1;
    expect_in(1, SEL_BP, 1, "R8");
    expect_in(1, SEL_WP, 1, "R8");
    expect_in(1, SEL_MSR, 32'h8002, "R12");
    tick(1); bp_req = 1'b0; wp_req = 1'b0; rfi_strobe = 1'b1;
    expect_in(1, SEL_BP, 0, "R8");
    expect_in(1, SEL_FRZ, 0, "R12");
    tick(1); rfi_strobe = 1'b0;
    // R5 disabled cause does not freeze; R3 read returns and clears
    evt_in = 32'h4;
    expect_in(2, SEL_FRZ, 0, "R5");
    tick(1); evt_in = '0;
    tick(1); bus_re = 1'b1; bus_addr = 2'd0;
    expect_in(1, SEL_RD, 32'h4, "R3");
    tick(1);
    expect_in(1, SEL_RD, 32'h0, "R3");
    tick(1); bus_re = 1'b0;
    // R5 / R6 entry
    evt_in = 32'h10;
    expect_in(1, SEL_FRZ, 0, "R5");
    expect_in(2, SEL_FRZ, 1, "R5");
    expect_in(2, SEL_SPC, 32'h1000, "R6");
    expect_in(2, SEL_SMSR, 32'h8002, "R6");
    expect_in(2, SEL_MSR, 32'h0002, "R6");
    tick(1); evt_in = '0;
    tick(1);
    // R7 / R8 / R9 while frozen
    cur_msr = 32'hFFFF_FFFF; cur_pc = 32'h2000; bp_req = 1'b1; wp_req = 1'b1;
    expect_in(1, SEL_BP, 0, "R8");
    expect_in(1, SEL_WP, 0, "R8");
    expect_in(1, SEL_MSR, 32'h2, "R7");
    expect_in(1, SEL_SPC, 32'h1000, "R7");
    tick(1); evt_in = 32'h1;
    expect_in(1, SEL_SUM, 1, "R9");
    expect_in(2, SEL_SPC, 32'h1000, "R7");
    expect_in(2, SEL_SMSR, 32'h8002, "R7");
    expect_in(2, SEL_FRZ, 1, "R7");
    tick(1); evt_in = '0;
    expect_in(1, SEL_SUM, 0, "R9");
    tick(1);
    // R11 return with enabled cause pending bounces
    rfi_strobe = 1'b1;
    expect_in(1, SEL_FRZ, 1, "R11");
    expect_in(1, SEL_SPC, 32'h1000, "R11");
    expect_in(1, SEL_MSR, 32'h2, "R11");
    tick(1); rfi_strobe = 1'b0;
    expect_in(1, SEL_FRZ, 1, "R11");
    tick(1);
    // R3 clear then R10 exit
    bus_re = 1'b1; bus_addr = 2'd0;
    expect_in(1, SEL_RD, 32'h11, "R3");
    tick(1); bus_re = 1'b0; cur_msr = 32'h8002; bp_req = 1'b0; wp_req = 1'b0;
    rfi_strobe = 1'b1;
    expect_in(1, SEL_FRZ, 0, "R10");
    expect_in(1, SEL_MSR, 32'h8002, "R10");
    tick(1); rfi_strobe = 1'b0; cur_msr = 32'h4000;
    expect_in(1, SEL_MSR, 32'h4000, "R12");
    tick(1);
    // R3 same-cycle read and event priority
    evt_in = 32'h4;
    tick(1); evt_in = 32'hC; bus_re = 1'b1; bus_addr = 2'd0;
    expect_in(1, SEL_RD, 32'h4, "R3");
    tick(1); evt_in = '0;
    expect_in(1, SEL_RD, 32'h8, "R3");
    tick(1); bus_re = 1'b0;
    // R4 unrecognized class ignored even when enabled
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h8000_0011;
    tick(1); bus_we = 1'b0; evt_in = 32'h8000_0000;
    expect_in(2, SEL_FRZ, 0, "R4");
    tick(1); evt_in = '0;
    tick(1); bus_re = 1'b1; bus_addr = 2'd0;
    expect_in(1, SEL_RD, 32'h0, "R4");
    tick(1); bus_re = 1'b0;
    // R6 second entry captures fresh state, R10 exit again
    cur_pc = 32'h3000; cur_msr = 32'h8000; evt_in = 32'h1;
    expect_in(2, SEL_FRZ, 1, "R5");
    expect_in(2, SEL_SPC, 32'h3000, "R6");
    expect_in(2, SEL_MSR, 32'h0, "R6");
    tick(1); evt_in = '0;
    tick(1); bus_re = 1'b1; bus_addr = 2'd0;
    tick(1); bus_re = 1'b0; rfi_strobe = 1'b1;
    expect_in(1, SEL_FRZ, 0, "R10");
    expect_in(1, SEL_MSR, 32'h8000, "R10");
    tick(1); rfi_strobe = 1'b0;
    tick(3);
    if (sbq.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual=%0d left expected=0", sbq.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule